// File: doc/BRIEF.md
# Serial-Contention Interrupt Arbiter

When an interrupt acknowledge begins, this block chooses which of N requesting modules answers it. Each module has a 4-bit arbitration ID, a 3-bit request level and a pending flag. An acknowledge arrives as a one-cycle start strobe with a 3-bit level. Every pending module whose request level equals that level becomes a contender. The contenders then compete bit-serially on their IDs, most significant bit first, over a shared wired-OR line. A contender whose current ID bit is 0 leaves the contest if the line reads 1 in that cycle. After four contention cycles the block gives one of three results for a single cycle: a one-hot grant to the surviving module, a spurious indication, or a configuration-error flag. The cycle after that carries a one-cycle done pulse.

Software must give every module that can request an interrupt a unique non-zero ID. The contention picks the largest ID, so 0001 is the weakest and 1111 the strongest. The result is spurious when no module contends, or when the only survivor carries ID 0000. Producing the vector and timing the bus belong to the surrounding logic.

Top module: `irq_contend_arb`

## Requirements
- R1: While reset is asserted and after its release, before any acknowledge, grant is all zero and spurious, done and cfg_dup_err are 0.
- R2: A module contends only when its pend bit is 1 and its level field mod_level[3i+2:3i] equals ack_level. Every other module, whatever its ID, can never be granted.
- R3: Among the contenders, the module with the numerically largest ID (mod_id[4i+3:4i], 1111 highest) gets grant bit i.
- R4: The result (grant, spurious or cfg_dup_err) is valid only in the fifth cycle after the clock edge that samples ack_start, and lasts exactly one cycle. A grant is one-hot.
- R5: If no module contends, spurious is 1 in the result cycle and grant stays zero.
- R6: If the single survivor has ID 0000, spurious is 1 and grant stays zero. A non-zero ID always beats an ID of 0000.
- R7: done is 1 for exactly one cycle, the cycle after the result cycle.
- R8: If more than one module survives with the same ID, cfg_dup_err is 1 in the result cycle, and grant and spurious stay 0.
- R9: An ack_start that arrives between the start strobe and the done cycle, inclusive, is ignored.
- R10: IDs, levels and pending flags are sampled at the edge that accepts ack_start. Changes after that edge do not affect the running contention.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ack_start | input | 1 | One-cycle strobe that starts an acknowledge |
| ack_level | input | 3 | Level being acknowledged |
| mod_id | input | 4*N | Arbitration ID of each module, module i at [4i+3:4i] |
| mod_level | input | 3*N | Request level of each module, module i at [3i+2:3i] |
| mod_pend | input | N | Pending request flag of each module |
| grant | output | N | One-hot grant to the winner during the result cycle |
| spurious | output | 1 | No valid winner during the result cycle |
| done | output | 1 | Pulse one cycle after the result |
| cfg_dup_err | output | 1 | Several survivors shared one ID |

## Verification
A contender that drops out wrongly, or survives when it should not, shows at the ports five cycles after the start strobe. The grant lands on the wrong module, or a cfg_dup_err or spurious appears where a grant belonged. A sequencer in the wrong state shifts or stretches the result and done pulses by at least one cycle. The reference model compares every output on every cycle, so any such error is caught in the cycle it becomes visible.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int ID_W  = 4;
  localparam int LVL_W = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_CONT, ST_RES, ST_DONE} irqc_state_e;

  // A contender leaves when the line carries a 1 it did not drive.
  function automatic logic loses_bit(input logic my_bit, input logic line);
    return line & ~my_bit;
  endfunction

  function automatic logic level_hit(input logic pend, input logic [LVL_W-1:0] lvl,
                                     input logic [LVL_W-1:0] ack);
    return pend && (lvl == ack);
  endfunction
endpackage

// File: rtl/irqc_seq.sv
module irqc_seq
  import irqc_pkg::*;
#(
  parameter int BITS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ack_start,
  output logic                    load,
  output logic                    step,
  output logic [$clog2(BITS)-1:0] bit_idx,
  output logic                    in_res,
  output logic                    in_done,
  output logic                    busy
);
  localparam int BW = $clog2(BITS);
  localparam logic [BW-1:0] TOP_BIT = BW'(BITS - 1);

  irqc_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      bit_idx <= '0;
    end else begin
      case (state)
        ST_IDLE: if (ack_start) begin
          state   <= ST_CONT;
          bit_idx <= TOP_BIT;
        end
        ST_CONT: begin
          if (bit_idx == '0) state <= ST_RES;
          else bit_idx <= bit_idx - 1'b1;
        end
        ST_RES:  state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load    = (state == ST_IDLE) && ack_start;
  assign step    = (state == ST_CONT);
  assign in_res  = (state == ST_RES);
  assign in_done = (state == ST_DONE);
  assign busy    = (state != ST_IDLE);
endmodule

// File: rtl/irqc_contender.sv
module irqc_contender
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [1:0]       bit_idx,
  input  logic             line,
  input  logic [ID_W-1:0]  id_in,
  input  logic [LVL_W-1:0] lvl_in,
  input  logic             pend_in,
  input  logic [LVL_W-1:0] ack_level,
  output logic             drive,
  output logic             active,
  output logic [ID_W-1:0]  id_q
);
  logic my_bit;
  assign my_bit = id_q[bit_idx];
  assign drive  = active & my_bit & step;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      id_q   <= '0;
    end else if (load) begin
      active <= level_hit(pend_in, lvl_in, ack_level);
      id_q   <= id_in;
    end else if (step && loses_bit(my_bit, line)) begin
      active <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_contend_arb.sv
module irq_contend_arb
  import irqc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ack_start,
  input  logic [LVL_W-1:0]   ack_level,
  input  logic [ID_W*N-1:0]  mod_id,
  input  logic [LVL_W*N-1:0] mod_level,
  input  logic [N-1:0]       mod_pend,
  output logic [N-1:0]       grant,
  output logic               spurious,
  output logic               done,
  output logic               cfg_dup_err
);
  logic            load, step, in_res, in_done, busy;
  logic [1:0]      bit_idx;
  logic [N-1:0]    drive_vec, active_vec;
  logic [ID_W-1:0] id_q [N];
  logic            bus_line;
  logic [ID_W-1:0] win_id;
  logic            surv_none, surv_one, surv_many;

  irqc_seq #(.BITS(ID_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .ack_start(ack_start),
    .load(load), .step(step), .bit_idx(bit_idx),
    .in_res(in_res), .in_done(in_done), .busy(busy)
  );

  for (genvar i = 0; i < N; i++) begin : g_mod
    irqc_contender cont_i (
      .clk(clk), .rst_n(rst_n), .load(load), .step(step),
      .bit_idx(bit_idx), .line(bus_line),
      .id_in(mod_id[ID_W*i +: ID_W]),
      .lvl_in(mod_level[LVL_W*i +: LVL_W]),
      .pend_in(mod_pend[i]), .ack_level(ack_level),
      .drive(drive_vec[i]), .active(active_vec[i]), .id_q(id_q[i])
    );
  end

  assign bus_line = |drive_vec;

  always_comb begin
    win_id = '0;
    for (int i = 0; i < N; i++)
      if (active_vec[i]) win_id = win_id | id_q[i];
  end

  assign surv_none = (active_vec == '0);
  assign surv_one  = ($countones(active_vec) == 1);
  assign surv_many = !surv_none && !surv_one;

  assign grant       = (in_res && surv_one && win_id != '0) ? active_vec : '0;
  assign spurious    = in_res && (surv_none || (surv_one && win_id == '0));
  assign cfg_dup_err = in_res && surv_many;
  assign done        = in_done;
endmodule

// File: rtl/irqc_arb_chk.sv
module irqc_arb_chk #(
  parameter int N = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy,
  input logic [N-1:0] grant,
  input logic         spurious,
  input logic         done,
  input logic         cfg_dup_err
);
  logic any_res;
  assign any_res = (grant != '0) || spurious || cfg_dup_err;

  a_r4_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0) |-> $onehot(grant));
  a_r4_result_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    any_res |=> !any_res);
  a_r4_result_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    any_res |-> busy);
  a_r7_done_follows: assert property (@(posedge clk) disable iff (!rst_n)
    any_res |=> done);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_dup_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_dup_err |-> (grant == '0 && !spurious));
  a_r5_spur_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    spurious |-> grant == '0);
endmodule

bind irq_contend_arb irqc_arb_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .busy(busy), .grant(grant),
  .spurious(spurious), .done(done), .cfg_dup_err(cfg_dup_err)
);

// File: tb/irq_contend_arb_tb_top.sv
module irq_contend_arb_tb_top;
  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           ack_start = 1'b0;
  logic [2:0]     ack_level = '0;
  logic [4*N-1:0] mod_id = '0;
  logic [3*N-1:0] mod_level = '0;
  logic [N-1:0]   mod_pend = '0;
  logic [N-1:0]   grant;
  logic           spurious, done, cfg_dup_err;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_contend_arb #(.N(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ack_start(ack_start), .ack_level(ack_level),
    .mod_id(mod_id), .mod_level(mod_level), .mod_pend(mod_pend),
    .grant(grant), .spurious(spurious), .done(done), .cfg_dup_err(cfg_dup_err)
  );

  // Reference model: phase counter plus an outcome decided at acceptance.
  int         ph = 0;
  logic [N-1:0] e_grant;
  bit         e_spur, e_dup;

  always @(posedge clk) begin
    if (!rst_n) ph = 0;
    else if (ph == 0) begin
      if (ack_start) begin
        int best, cnt, who;
        best = -1; cnt = 0; who = 0;
        for (int i = 0; i < N; i++) begin
          int idv;
          idv = int'(mod_id[4*i +: 4]);
          if (mod_pend[i] && mod_level[3*i +: 3] == ack_level) begin
            if (idv > best) begin best = idv; cnt = 1; who = i; end
            else if (idv == best) cnt++;
          end
        end
        e_grant = '0; e_spur = 0; e_dup = 0;
        if (best < 0) e_spur = 1;
        else if (cnt > 1) e_dup = 1;
        else if (best == 0) e_spur = 1;
        else e_grant[who] = 1'b1;
        ph = 1;
      end
    end else ph = (ph == 6) ? 0 : ph + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    chk("R3 grant", int'(grant), (ph == 5) ? int'(e_grant) : 0);
    chk("R5,R6 spurious", int'(spurious), (ph == 5) ? int'(e_spur) : 0);
    chk("R7 done", int'(done), (ph == 6) ? 1 : 0);
    chk("R8 cfg_dup_err", int'(cfg_dup_err), (ph == 5) ? int'(e_dup) : 0);
  end

  task automatic set_mod(input int i, input int idv, input int lvl, input bit p);
    mod_id[4*i +: 4]    = 4'(idv);
    mod_level[3*i +: 3] = 3'(lvl);
    mod_pend[i]         = p;
  endtask

  task automatic do_ack(input int lvl);
    @(negedge clk); ack_start = 1'b1; ack_level = 3'(lvl);
    @(negedge clk); ack_start = 1'b0;
    repeat (7) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk("R1 grant", int'(grant), 0);
    chk("R1 flags", int'({spurious, done, cfg_dup_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3: highest ID wins among all-matching modules
    set_mod(0, 3, 5, 1); set_mod(1, 12, 5, 1); set_mod(2, 7, 5, 1); set_mod(3, 1, 5, 1);
    do_ack(5);
    // R2: higher ID at another level and higher ID not pending are excluded
    set_mod(1, 15, 2, 1); set_mod(2, 14, 5, 0);
    do_ack(5);
    // R5: no contenders
    do_ack(6);
    // R6: lone zero ID is spurious; zero loses to non-zero
    set_mod(0, 0, 4, 1); set_mod(3, 1, 3, 1);
    do_ack(4);
    set_mod(3, 1, 4, 1);
    do_ack(4);
    // R8: duplicate IDs
    set_mod(0, 9, 1, 1); set_mod(1, 9, 1, 1); set_mod(2, 2, 1, 1); set_mod(3, 4, 1, 1);
    do_ack(1);
    // R9 and R10: a second strobe and input changes mid-contention have no effect
    set_mod(0, 6, 7, 1); set_mod(1, 10, 7, 1); set_mod(2, 8, 7, 1); set_mod(3, 2, 3, 1);
    @(negedge clk); ack_start = 1'b1; ack_level = 3'd7;
    @(negedge clk); ack_start = 1'b0;
    @(negedge clk); ack_start = 1'b1; ack_level = 3'd3;
    set_mod(1, 1, 7, 0); set_mod(0, 15, 7, 1);
    @(negedge clk); ack_start = 1'b0;
    repeat (6) @(negedge clk);
    // Pseudo-random transactions with unique IDs (R2, R3)
    for (int t = 0; t < 40; t++) begin
      int base;
      base = int'($urandom % 15);
      for (int i = 0; i < N; i++)
        set_mod(i, ((base + i * 4) % 15) + 1, int'($urandom % 3) + 1, 1'($urandom % 2));
      do_ack(int'($urandom % 3) + 1);
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule